// File: doc/BRIEF.md
# Configurable PRBS Generator and Checker

This block drives a 32-bit-per-clock pseudo-random test pattern onto a transmit data path and checks a 32-bit receive data path against a local copy of the same sequence. One of seven standard polynomials, or a repeated 32-bit user word, is chosen by a 3-bit select. The receive checker locks onto the incoming stream by itself: the first valid word after the receive side is loaded fills the local register, and every later word is compared bit by bit against the local prediction.

A single 16-bit command word controls both sides. The low byte holds the pattern select and the option bits, and the high byte holds the load bits for each side. Three reserved command values turn off one side or both. Mismatched bits go into a 32-bit saturating error counter. The counter can be cleared, can be frozen by a busy input, and can be copied into a snapshot. The snapshot is read out as a low half followed by a high half. A lock flag shows a run of clean words, and a halt flag shows that checking stopped on an error.

Top module: `prbs_engine`

## Requirements
- R1: A command with code[8]=1 (and not a disable code) loads the transmit side with pattern select code[2:0]: 0=PRBS7 (x^7+x^6+1), 1=PRBS9 (x^9+x^5+1), 2=PRBS11 (x^11+x^9+1), 3=PRBS15 (x^15+x^14+1), 4=PRBS23 (x^23+x^18+1), 5=PRBS31 (x^31+x^28+1), 6=PRBS13 (x^13+x^12+x^2+x+1). The register is seeded all ones and tx_data is zero in the cycle after the load. From the next clock on, one 32-bit word appears per clock. Bit 31 is the earliest bit, and each new bit is the XOR of the register bits at the tap exponents (exponent e at register bit e-1). The new bit then shifts in at bit 0.
- R2: Select 7 repeats the user_word input on tx_data every clock. For the checker, it makes user_word the expected value of every word.
- R3: Command 0x3FF turns off both sides, 0x1FF only the transmit side (tx_active=0, tx_data=0) and 0x2FF only the receive side (rx_active=0). The other side is left as it was.
- R4: A command with code[9]=1 loads the receive side with the options in code[7:0]. The first valid word after the load seeds the local register from its low bits and is not compared. Each later valid word adds one error for every bit that differs from the prediction.
- R5: With code[4] set, an errored word reseeds the local register from that word, so a phase jump in the stream costs a single errored word.
- R6: With code[5] set, a local register that holds all zeros is replaced by all ones before the next word is predicted.
- R7: With code[7] set, the first errored word is still counted, then rx_halted rises and no later word is compared or counted until the receive side is reloaded.
- R8: The error counter adds the errors of words compared while busy is low. Errors of words compared while busy is high are dropped. cnt_clear sets it to zero, and it holds at 0xFFFFFFFF rather than wrapping.
- R9: cnt_latch copies the counter into a snapshot. The first cnt_read after a latch returns snapshot bits [15:0] on rd_data, and the next returns bits [31:16].
- R10: rx_lock rises after 32 consecutive error-free compared words and falls after any errored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Command strobe |
| cfg_code | input | 16 | Command word: high byte loads, low byte select and options |
| user_word | input | 32 | Programmable word for select 7 |
| busy | input | 1 | Blocks error accumulation while high |
| tx_data | output | 32 | Generated pattern word |
| tx_active | output | 1 | Transmit side running |
| rx_valid | input | 1 | rx_data holds a word |
| rx_data | input | 32 | Received word, bit 31 earliest |
| rx_active | output | 1 | Receive side running |
| rx_lock | output | 1 | 32 clean words in a row |
| rx_halted | output | 1 | Checking stopped on an error |
| cnt_clear | input | 1 | Clear the error counter |
| cnt_latch | input | 1 | Copy the counter into the snapshot |
| cnt_read | input | 1 | Return the next snapshot half |
| rd_data | output | 16 | Snapshot half from the last read |

## Verification
A wrong tap or a wrong bit order in the shared unrolled step shows as a tx_data mismatch in the first word after a load, one clock after the load clock. The same error in the checker shows as a nonzero snapshot after a clean stream. A wrong seed, reseed or all-zero correction leaves the local register out of phase. It then adds errors on every later word, and the bench sees this in the counter a few cycles later. A wrong run counter or halt flag shows at rx_lock or rx_halted in the clock that follows the word that should have changed it.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
    localparam int WORD_W = 32;
    localparam int ST_W   = 32;
    localparam int BITS_W = $clog2(WORD_W + 1);

    localparam logic [15:0] CODE_OFF_BOTH = 16'h03FF;
    localparam logic [15:0] CODE_OFF_TX   = 16'h01FF;
    localparam logic [15:0] CODE_OFF_RX   = 16'h02FF;

    typedef enum logic [2:0] {
        PAT_P7   = 3'd0,
        PAT_P9   = 3'd1,
        PAT_P11  = 3'd2,
        PAT_P15  = 3'd3,
        PAT_P23  = 3'd4,
        PAT_P31  = 3'd5,
        PAT_P13  = 3'd6,
        PAT_USER = 3'd7
    } pat_e;

    // Low command byte; field positions are decoded by the top
    typedef struct packed {
        logic stop;
        logic rsv6;
        logic fix;
        logic reseed;
        logic rsv3;
        pat_e sel;
    } opt_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [ST_W-1:0]   nxt;
    } adv_t;

    function automatic logic [ST_W-1:0] len_mask(pat_e sel);
        case (sel)
            PAT_P7:  return ST_W'(32'h0000_007F);
            PAT_P9:  return ST_W'(32'h0000_01FF);
            PAT_P11: return ST_W'(32'h0000_07FF);
            PAT_P15: return ST_W'(32'h0000_7FFF);
            PAT_P23: return ST_W'(32'h007F_FFFF);
            PAT_P31: return ST_W'(32'h7FFF_FFFF);
            PAT_P13: return ST_W'(32'h0000_1FFF);
            default: return '1;
        endcase
    endfunction

    // Register bit e-1 for every tap exponent e other than zero
    function automatic logic [ST_W-1:0] tap_mask(pat_e sel);
        case (sel)
            PAT_P7:  return ST_W'(32'h0000_0060);
            PAT_P9:  return ST_W'(32'h0000_0110);
            PAT_P11: return ST_W'(32'h0000_0500);
            PAT_P15: return ST_W'(32'h0000_6000);
            PAT_P23: return ST_W'(32'h0042_0000);
            PAT_P31: return ST_W'(32'h4800_0000);
            PAT_P13: return ST_W'(32'h0000_1803);
            default: return '0;
        endcase
    endfunction

    // One clock of the unrolled shift register: earliest bit lands in the MSB
    function automatic adv_t prbs_advance(logic [ST_W-1:0] st, pat_e sel,
                                          logic [WORD_W-1:0] usr, logic fix0);
        adv_t            r;
        logic [ST_W-1:0] lm;
        logic [ST_W-1:0] s;
        logic            fb;
        lm = len_mask(sel);
        s  = st & lm;
        if (fix0 && (s == '0)) s = lm;
        r = '0;
        if (sel == PAT_USER) begin
            r.word = usr;
        end else begin
            for (int i = WORD_W - 1; i >= 0; i--) begin
                fb        = ^(s & tap_mask(sel));
                r.word[i] = fb;
                s         = ((s << 1) | {{(ST_W-1){1'b0}}, fb}) & lm;
            end
        end
        r.nxt = s;
        return r;
    endfunction
endpackage

// File: rtl/prbs_tx_gen.sv
module prbs_tx_gen
    import prbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              off,
    input  pat_e              sel_in,
    input  logic              fix_in,
    input  logic [WORD_W-1:0] usr,
    output logic [WORD_W-1:0] tx_data,
    output logic              tx_active
);
    logic [ST_W-1:0] st_q;
    pat_e            sel_q;
    logic            fix_q;
    adv_t            adv;

    always_comb adv = prbs_advance(st_q, sel_q, usr, fix_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            sel_q     <= PAT_P7;
            fix_q     <= 1'b0;
            tx_active <= 1'b0;
            tx_data   <= '0;
        end else if (load) begin
            st_q      <= len_mask(sel_in);
            sel_q     <= sel_in;
            fix_q     <= fix_in;
            tx_active <= 1'b1;
            tx_data   <= '0;
        end else if (off) begin
            tx_active <= 1'b0;
            tx_data   <= '0;
        end else if (tx_active) begin
            st_q    <= adv.nxt;
            tx_data <= adv.word;
        end
    end

    assert_tx_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !tx_active |-> (tx_data == '0));
endmodule

// File: rtl/prbs_rx_chk.sv
module prbs_rx_chk
    import prbs_pkg::*;
#(
    parameter int LOCK_WORDS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              off,
    input  opt_t              opt_in,
    input  logic [WORD_W-1:0] usr,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    output logic              cmp_fire,
    output logic [BITS_W-1:0] cmp_bits,
    output logic              rx_active,
    output logic              rx_lock,
    output logic              rx_halted
);
    localparam int RUN_W = $clog2(LOCK_WORDS + 1);

    logic [ST_W-1:0]  st_q;
    logic [RUN_W-1:0] run_q;
    logic             seeded_q;
    pat_e             sel_q;
    logic             reseed_q, fix_q, stop_q;
    adv_t             adv;
    logic [ST_W-1:0]  lm;

    always_comb begin
        lm       = len_mask(sel_q);
        adv      = prbs_advance(st_q, sel_q, usr, fix_q);
        cmp_bits = BITS_W'($countones(rx_data ^ adv.word));
        cmp_fire = rx_active && seeded_q && !rx_halted && rx_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            run_q     <= '0;
            seeded_q  <= 1'b0;
            sel_q     <= PAT_P7;
            reseed_q  <= 1'b0;
            fix_q     <= 1'b0;
            stop_q    <= 1'b0;
            rx_active <= 1'b0;
            rx_lock   <= 1'b0;
            rx_halted <= 1'b0;
        end else if (load) begin
            st_q      <= '0;
            run_q     <= '0;
            seeded_q  <= 1'b0;
            sel_q     <= opt_in.sel;
            reseed_q  <= opt_in.reseed;
            fix_q     <= opt_in.fix;
            stop_q    <= opt_in.stop;
            rx_active <= 1'b1;
            rx_lock   <= 1'b0;
            rx_halted <= 1'b0;
        end else if (off) begin
            seeded_q  <= 1'b0;
            run_q     <= '0;
            rx_active <= 1'b0;
            rx_lock   <= 1'b0;
            rx_halted <= 1'b0;
        end else if (rx_active && rx_valid && !rx_halted) begin
            if (!seeded_q) begin
                st_q     <= rx_data & lm;
                seeded_q <= 1'b1;
            end else if (cmp_bits != '0) begin
                run_q     <= '0;
                rx_lock   <= 1'b0;
                rx_halted <= stop_q;
                st_q      <= reseed_q ? (rx_data & lm) : adv.nxt;
            end else begin
                st_q <= adv.nxt;
                if (run_q < RUN_W'(LOCK_WORDS)) run_q <= run_q + 1'b1;
                if (run_q == RUN_W'(LOCK_WORDS - 1)) rx_lock <= 1'b1;
            end
        end
    end

    assert_halt_needs_stop_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_halted) |-> stop_q);

    assert_lock_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (cmp_fire && (cmp_bits != '0) && !load && !off) |=> !rx_lock);
endmodule

// File: rtl/prbs_err_acc.sv
module prbs_err_acc
    import prbs_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic [BITS_W-1:0]  bits,
    input  logic               busy,
    input  logic               clr,
    input  logic               latch,
    input  logic               rd,
    output logic [CNT_W/2-1:0] rd_data
);
    localparam int HALF_W = CNT_W / 2;

    logic [BITS_W-1:0] pend_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  snap_q;
    logic              hi_q;
    logic [CNT_W:0]    sum;

    always_comb sum = {1'b0, cnt_q} + (CNT_W+1)'(pend_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            pend_q <= '0;
            cnt_q  <= '0;
        end else begin
            pend_q <= (fire && !busy) ? bits : '0;
            cnt_q  <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q  <= '0;
            hi_q    <= 1'b0;
            rd_data <= '0;
        end else if (latch) begin
            snap_q <= cnt_q;
            hi_q   <= 1'b0;
        end else if (rd) begin
            rd_data <= hi_q ? snap_q[CNT_W-1:HALF_W] : snap_q[HALF_W-1:0];
            hi_q    <= !hi_q;
        end
    end

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt_q < $past(cnt_q)) |-> $past(clr));

    assert_busy_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !clr) ##1 !clr |=> $stable(cnt_q));

    assert_snap_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !latch |=> $stable(snap_q));
endmodule

// File: rtl/prbs_engine.sv
module prbs_engine
    import prbs_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int LOCK_WORDS = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_valid,
    input  logic [15:0]        cfg_code,
    input  logic [WORD_W-1:0]  user_word,
    input  logic               busy,
    output logic [WORD_W-1:0]  tx_data,
    output logic               tx_active,
    input  logic               rx_valid,
    input  logic [WORD_W-1:0]  rx_data,
    output logic               rx_active,
    output logic               rx_lock,
    output logic               rx_halted,
    input  logic               cnt_clear,
    input  logic               cnt_latch,
    input  logic               cnt_read,
    output logic [CNT_W/2-1:0] rd_data
);
    opt_t              opt;
    logic              is_off;
    logic              off_tx, off_rx, load_tx, load_rx;
    logic              cmp_fire;
    logic [BITS_W-1:0] cmp_bits;
    logic              unused_rsv;

    always_comb begin
        opt     = opt_t'(cfg_code[7:0]);
        is_off  = (cfg_code == CODE_OFF_BOTH) || (cfg_code == CODE_OFF_TX) ||
                  (cfg_code == CODE_OFF_RX);
        off_tx  = cfg_valid && ((cfg_code == CODE_OFF_BOTH) || (cfg_code == CODE_OFF_TX));
        off_rx  = cfg_valid && ((cfg_code == CODE_OFF_BOTH) || (cfg_code == CODE_OFF_RX));
        load_tx = cfg_valid && !is_off && cfg_code[8];
        load_rx = cfg_valid && !is_off && cfg_code[9];
    end

    assign unused_rsv = ^{opt.rsv3, opt.rsv6};

    prbs_tx_gen u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (load_tx),
        .off       (off_tx),
        .sel_in    (opt.sel),
        .fix_in    (opt.fix),
        .usr       (user_word),
        .tx_data   (tx_data),
        .tx_active (tx_active)
    );

    prbs_rx_chk #(.LOCK_WORDS(LOCK_WORDS)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .load      (load_rx),
        .off       (off_rx),
        .opt_in    (opt),
        .usr       (user_word),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .cmp_fire  (cmp_fire),
        .cmp_bits  (cmp_bits),
        .rx_active (rx_active),
        .rx_lock   (rx_lock),
        .rx_halted (rx_halted)
    );

    prbs_err_acc #(.CNT_W(CNT_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .fire    (cmp_fire),
        .bits    (cmp_bits),
        .busy    (busy),
        .clr     (cnt_clear),
        .latch   (cnt_latch),
        .rd      (cnt_read),
        .rd_data (rd_data)
    );

    assert_off_keeps_rx_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && (cfg_code == CODE_OFF_TX) && rx_active) |=> rx_active);
endmodule

// File: tb/tb_prbs_engine.sv
module tb_prbs_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_valid = 1'b0;
    logic [15:0] cfg_code = '0;
    logic [31:0] user_word = '0;
    logic        busy = 1'b0;
    logic [31:0] tx_data;
    logic        tx_active;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic        rx_active, rx_lock, rx_halted;
    logic        cnt_clear = 1'b0, cnt_latch = 1'b0, cnt_read = 1'b0;
    logic [15:0] rd_data;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    prbs_engine dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_mask(input int sel);
        int n;
        case (sel)
            0: n = 7;  1: n = 9;  2: n = 11; 3: n = 15;
            4: n = 23; 5: n = 31; default: n = 13;
        endcase
        return 32'((64'd1 << n) - 64'd1);
    endfunction

    function automatic logic m_fb(input logic [31:0] s, input int sel);
        case (sel)
            0: return s[6] ^ s[5];
            1: return s[8] ^ s[4];
            2: return s[10] ^ s[8];
            3: return s[14] ^ s[13];
            4: return s[22] ^ s[17];
            5: return s[30] ^ s[27];
            default: return s[12] ^ s[11] ^ s[1] ^ s[0];
        endcase
    endfunction

    task automatic nw(inout logic [31:0] st, input int sel, output logic [31:0] w);
        logic b;
        for (int i = 31; i >= 0; i--) begin
            b    = m_fb(st, sel);
            w[i] = b;
            st   = ((st << 1) | {31'd0, b}) & m_mask(sel);
        end
    endtask

    function automatic logic [31:0] mk_flip(input int k);
        logic [31:0] m = '0;
        while ($countones(m) < k) m[$urandom % 32] = 1'b1;
        return m;
    endfunction

    task automatic cfg(input logic [15:0] c);
        @(negedge clk); cfg_valid = 1'b1; cfg_code = c;
        @(posedge clk); #1 cfg_valid = 1'b0;
    endtask

    task automatic feed(input logic [31:0] w);
        @(negedge clk); rx_valid = 1'b1; rx_data = w;
        @(posedge clk); #1 rx_valid = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); cnt_clear = 1'b1;
        @(posedge clk); #1 cnt_clear = 1'b0;
    endtask

    task automatic read_count(output logic [15:0] lo, output logic [15:0] hi);
        repeat (3) @(posedge clk);
        @(negedge clk); cnt_latch = 1'b1;
        @(posedge clk); #1 cnt_latch = 1'b0;
        @(negedge clk); cnt_read = 1'b1;
        @(posedge clk); #1 cnt_read = 1'b0; lo = rd_data;
        @(negedge clk); cnt_read = 1'b1;
        @(posedge clk); #1 cnt_read = 1'b0; hi = rd_data;
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] ms, w, e, fl, ms2;
        logic [15:0] lo, hi;
        int          exp_err;
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        chk("reset tx_data", tx_data, 0);
        chk("reset flags", {tx_active, rx_active, rx_lock, rx_halted}, 0);
        chk("reset rd_data", rd_data, 0);

        // R1: every polynomial from an all-ones seed
        for (int s = 0; s < 7; s++) begin
            cfg({8'h01, 5'b0, 3'(s)});
            chk("R1 first cycle zero", tx_data, 0);
            ms = m_mask(s);
            for (int k = 0; k < 6; k++) begin
                @(posedge clk); #1;
                nw(ms, s, e);
                chk($sformatf("R1 sel%0d word%0d", s, k), tx_data, e);
            end
        end

        // R2: user word repeats
        user_word = $urandom;
        cfg(16'h0107);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            chk("R2 user word", tx_data, user_word);
        end

        // R3: disable codes
        cfg(16'h0205);
        cfg(16'h01FF);
        chk("R3 tx off", {tx_active, tx_data}, 0);
        chk("R3 rx untouched", rx_active, 1);
        cfg(16'h0105);
        cfg(16'h02FF);
        chk("R3 rx off", rx_active, 0);
        chk("R3 tx untouched", tx_active, 1);
        cfg(16'h0305);
        cfg(16'h03FF);
        chk("R3 both off", {tx_active, rx_active}, 0);

        // R4 and R10: plain checking, bit counting, lock run
        do_clear();
        cfg(16'h0205);
        ms = $urandom & 32'h7FFF_FFFF; if (ms == 0) ms = 1;
        nw(ms, 5, w); feed(w);
        exp_err = 0;
        for (int i = 1; i <= 44; i++) begin
            nw(ms, 5, w);
            fl = (i == 11) ? mk_flip(3) : (i == 44) ? mk_flip(1) : 32'd0;
            exp_err += $countones(fl);
            feed(w ^ fl);
            if (i == 42) chk("R10 31 clean words no lock", rx_lock, 0);
            if (i == 43) chk("R10 32 clean words lock", rx_lock, 1);
            if (i == 44) chk("R10 errored word drops lock", rx_lock, 0);
        end
        read_count(lo, hi);
        chk("R4 error bits counted", {hi, lo}, exp_err);

        // R5: phase jump with reseed costs one word
        do_clear();
        cfg(16'h0215);
        ms = $urandom & 32'h7FFF_FFFF; if (ms == 0) ms = 3;
        nw(ms, 5, w); feed(w);
        for (int i = 0; i < 5; i++) begin nw(ms, 5, w); feed(w); end
        nw(ms, 5, e);
        ms2 = $urandom & 32'h7FFF_FFFF; if (ms2 == 0) ms2 = 5;
        nw(ms2, 5, w); feed(w);
        exp_err = $countones(w ^ e);
        for (int i = 0; i < 10; i++) begin nw(ms2, 5, w); feed(w); end
        read_count(lo, hi);
        chk("R5 reseed single errored word", {hi, lo}, exp_err);

        // R6: zero seed corrected to all ones
        do_clear();
        cfg(16'h0220);
        feed(32'd0);
        ms = 32'h7F;
        for (int i = 0; i < 8; i++) begin nw(ms, 0, w); feed(w); end
        read_count(lo, hi);
        chk("R6 all-zero state forced to ones", {hi, lo}, 0);

        // R7: stop on error
        do_clear();
        cfg(16'h0285);
        ms = $urandom & 32'h7FFF_FFFF; if (ms == 0) ms = 9;
        nw(ms, 5, w); feed(w);
        for (int i = 0; i < 3; i++) begin nw(ms, 5, w); feed(w); end
        chk("R7 not halted while clean", rx_halted, 0);
        nw(ms, 5, w); feed(w ^ mk_flip(2));
        chk("R7 halted after error", rx_halted, 1);
        for (int i = 0; i < 3; i++) begin nw(ms, 5, w); feed(~w); end
        read_count(lo, hi);
        chk("R7 only first errored word counted", {hi, lo}, 2);

        // R8: busy drops errors, clear zeroes
        do_clear();
        cfg(16'h0205);
        ms = $urandom & 32'h7FFF_FFFF; if (ms == 0) ms = 11;
        nw(ms, 5, w); feed(w);
        for (int i = 0; i < 2; i++) begin nw(ms, 5, w); feed(w); end
        busy = 1'b1;
        nw(ms, 5, w); feed(w ^ mk_flip(5));
        nw(ms, 5, w); feed(w);
        busy = 1'b0;
        nw(ms, 5, w); feed(w ^ mk_flip(1));
        nw(ms, 5, w); feed(w);
        read_count(lo, hi);
        chk("R8 busy errors dropped", {hi, lo}, 1);
        do_clear();
        read_count(lo, hi);
        chk("R8 clear zeroes count", {hi, lo}, 0);

        // R9: count above 16 bits read as two halves
        user_word = $urandom;
        cfg(16'h0207);
        feed(user_word);
        for (int i = 0; i < 2100; i++) feed(~user_word);
        read_count(lo, hi);
        chk("R9 low half", lo, 16'd1664);
        chk("R9 high half", hi, 16'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule